// File: doc/BRIEF.md
# Paged Nonvolatile Memory Burst Writer

This controller sits on the host side of a byte-wide paged nonvolatile memory bus. A client hands it one request: a start address, a byte count, and a flag that asks for the write-unlock prefix. The client then streams the payload bytes over a valid/ready channel. The controller generates the active-low chip-enable, write-enable and output-enable strobes together with the address and data buses. Each strobe meets its minimum width, its setup and hold rules, and the maximum spacing between byte loads.

After the last byte has been loaded, the memory programs the page on its own. During that time a read of the last written location returns bit 7 inverted. The controller reads that location over and over and compares the returned bit 7 with the bit it wrote. When they agree it raises a one-cycle `done`. It raises a one-cycle `err` with a code in three cases: the request is illegal, the payload stalls too long between bytes, or the bit never agrees within a poll budget.

All times are parameters counted in clock cycles. Each is chosen by rounding the nanosecond minimum up to whole periods of the system clock.

Top module: `nvm_page_writer`

## Requirements
- R1: A request is rejected in the cycle it is taken when any of these holds: its count is 0, its count exceeds the page size (64 bytes by default), or the start offset within the page plus the count exceeds the page size. On rejection the block pulses `err` for one cycle with `errCode` = 1 and drives no bus strobe.
- R2: Every write strobe holds `memWeN` low for at least T_WP cycles. `memCeN` is low and `memOeN` is high for the whole of that interval.
- R3: Between two write strobes, `memWeN` stays high for at least T_WPH cycles.
- R4: `memAddr` and `memDout` keep the same value throughout each low phase of `memWeN`.
- R5: The data strobes of one request target start address + i for i = 0 .. count-1, in that order. They carry the streamed bytes in stream order, so all of them share the address bits above the page offset. The memory ends up holding those bytes.
- R6: With `reqUnlock` set, three strobes come before the data: 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. With the flag clear, no such strobes are issued.
- R7: After a strobe begins, the next byte must be offered within GAP_LIMIT cycles. If it is not, the request is abandoned with a one-cycle `err`, `errCode` = 2, and all strobes inactive.
- R8: After the last data strobe, the block reads the last written address with `memCeN` and `memOeN` low and `memWeN` high. Between reads it raises both strobes for T_RCV cycles. It pulses `done` only after a read in which `memPollBit` equals bit 7 of the last byte written.
- R9: After POLL_LIMIT consecutive mismatching reads, the block pulses `err` with `errCode` = 3 and returns to idle.
- R10: After reset, and whenever no request is in progress, all three strobes are high and `reqReady` is 1. `reqReady` and `inReady` are never high together, and `done` and `err` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqAddr | input | 15 | Start address of the burst |
| reqCount | input | 7 | Number of bytes, 1..64 |
| reqUnlock | input | 1 | Issue the three-byte unlock prefix first |
| reqReady | output | 1 | Controller idle, request is taken this cycle |
| inValid | input | 1 | Payload byte offered |
| inData | input | 8 | Payload byte |
| inReady | output | 1 | Payload byte is taken this cycle |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memAddr | output | 15 | Memory address bus |
| memDout | output | 8 | Data driven toward the memory |
| memDrive | output | 1 | High while the host owns the data bus |
| memPollBit | input | 1 | Bit 7 of the data bus as read from the memory |
| done | output | 1 | One-cycle pulse: burst programmed |
| err | output | 1 | One-cycle pulse: request failed |
| errCode | output | 2 | Reason for the last error: 1 rejected, 2 payload gap, 3 poll timeout |

## Verification
The poll-timeout abort is the hardest case to reach from the ports, because a well-behaved memory always finishes programming. The bench's memory model has a switch that freezes its busy countdown. While frozen, every read returns the inverted bit, so the full poll budget runs out. The payload-gap abort needs a stream that stops partway through a burst. The bench offers only the first byte of a four-byte request and then withholds the rest, while a shortened gap limit keeps the run short.

// File: rtl/nvmw_pkg.sv
package nvmw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEXT,
    ST_WLOW,
    ST_WHIGH,
    ST_PREAD,
    ST_PGAP
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;
    logic capByte;
    logic stepPrefix;
    logic stepByte;
  } dpStrobe_t;

  localparam logic [1:0] ERR_REQ  = 2'd1;
  localparam logic [1:0] ERR_GAP  = 2'd2;
  localparam logic [1:0] ERR_POLL = 2'd3;

  localparam int UNLOCK_LEN = 3;

  function automatic logic [14:0] unlockAddr(input logic [1:0] step);
    case (step)
      2'd1:    return 15'h2AAA;
      default: return 15'h5555;
    endcase
  endfunction

  function automatic logic [7:0] unlockData(input logic [1:0] step);
    case (step)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/nvmw_dpath.sv
module nvmw_dpath
  import nvmw_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              reqUnlock,
  input  logic [DATA_W-1:0] inData,
  input  logic              memPollBit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              inPrefix,
  output logic              lastByte,
  output logic              pollMatch
);

  localparam logic [1:0] PFX_LAST = 2'(UNLOCK_LEN - 1);

  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  cntReg;
  logic [CNT_W-1:0]  idx;
  logic [1:0]        pfxIdx;
  logic              pfxOn;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      cntReg   <= '0;
      idx      <= '0;
      pfxIdx   <= '0;
      pfxOn    <= 1'b0;
      dataReg  <= '0;
    end else begin
      if (stb.capReq) begin
        baseAddr <= reqAddr;
        cntReg   <= reqCount;
        idx      <= '0;
        pfxIdx   <= '0;
        pfxOn    <= reqUnlock;
      end
      if (stb.stepPrefix) begin
        if (pfxIdx == PFX_LAST) pfxOn <= 1'b0;
        else pfxIdx <= pfxIdx + 2'd1;
      end
      if (stb.capByte) dataReg <= inData;
      if (stb.stepByte) idx <= idx + CNT_W'(1);
    end
  end

  // after the final byte idx is left in place, so the poll address is the last one written
  assign memAddr   = pfxOn ? ADDR_W'(unlockAddr(pfxIdx)) : baseAddr + ADDR_W'(idx);
  assign memDout   = pfxOn ? DATA_W'(unlockData(pfxIdx)) : dataReg;
  assign inPrefix  = pfxOn;
  assign lastByte  = (idx == cntReg - CNT_W'(1));
  assign pollMatch = (memPollBit == dataReg[DATA_W-1]);

endmodule

// File: rtl/nvmw_ctrl.sv
module nvmw_ctrl
  import nvmw_pkg::*;
#(
  parameter int PAGE_W     = 6,
  parameter int CNT_W      = 7,
  parameter int T_WP       = 13,
  parameter int T_WPH      = 7,
  parameter int T_ACC      = 19,
  parameter int T_RCV      = 7,
  parameter int GAP_LIMIT  = 18000,
  parameter int POLL_LIMIT = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [PAGE_W-1:0] reqOffset,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              inValid,
  input  logic              inPrefix,
  input  logic              lastByte,
  input  logic              pollMatch,
  output dpStrobe_t         stb,
  output logic              reqReady,
  output logic              inReady,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memDrive,
  output logic              done,
  output logic              err,
  output logic [1:0]        errCode
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TMR_W  = $clog2(T_WP + T_WPH + T_ACC + T_RCV) + 1;
  localparam int GAP_W  = $clog2(GAP_LIMIT + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  localparam logic [TMR_W-1:0]  WP_END   = TMR_W'(T_WP - 1);
  localparam logic [TMR_W-1:0]  WPH_END  = TMR_W'(T_WPH - 1);
  localparam logic [TMR_W-1:0]  ACC_END  = TMR_W'(T_ACC - 1);
  localparam logic [TMR_W-1:0]  RCV_END  = TMR_W'(T_RCV - 1);
  localparam logic [GAP_W-1:0]  GAP_MAX  = GAP_W'(GAP_LIMIT);
  localparam logic [POLL_W-1:0] POLL_END = POLL_W'(POLL_LIMIT - 1);
  localparam logic [CNT_W:0]    SPAN_MAX = (CNT_W+1)'(PAGE_BYTES);

  ctlState_t st, stNext;
  logic [TMR_W-1:0]  tmr;
  logic [GAP_W-1:0]  gapCnt;
  logic [POLL_W-1:0] pollCnt;
  logic tmrClr, gapClr, pollClr, pollInc;
  logic doneNext, errNext;
  logic [1:0] codeNext;
  logic [CNT_W:0] spanEnd;
  logic reqBad;

  assign spanEnd = (CNT_W+1)'(reqOffset) + (CNT_W+1)'(reqCount);
  assign reqBad  = (reqCount == '0) || ({1'b0, reqCount} > SPAN_MAX) || (spanEnd > SPAN_MAX);

  always_comb begin
    stNext   = st;
    stb      = '0;
    tmrClr   = 1'b0;
    gapClr   = 1'b0;
    pollClr  = 1'b0;
    pollInc  = 1'b0;
    doneNext = 1'b0;
    errNext  = 1'b0;
    codeNext = errCode;
    case (st)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqBad) begin
            errNext  = 1'b1;
            codeNext = ERR_REQ;
          end else begin
            stb.capReq = 1'b1;
            gapClr     = 1'b1;
            stNext     = ST_NEXT;
          end
        end
      end
      ST_NEXT: begin
        if (inPrefix) begin
          stNext = ST_WLOW;
          tmrClr = 1'b1;
          gapClr = 1'b1;
        end else if (inValid) begin
          stb.capByte = 1'b1;
          stNext      = ST_WLOW;
          tmrClr      = 1'b1;
          gapClr      = 1'b1;
        end else if (gapCnt >= GAP_MAX) begin
          errNext  = 1'b1;
          codeNext = ERR_GAP;
          stNext   = ST_IDLE;
        end
      end
      ST_WLOW: begin
        if (tmr == WP_END) begin
          stNext = ST_WHIGH;
          tmrClr = 1'b1;
        end
      end
      ST_WHIGH: begin
        if (tmr == WPH_END) begin
          tmrClr = 1'b1;
          if (inPrefix) begin
            stb.stepPrefix = 1'b1;
            stNext         = ST_NEXT;
          end else if (lastByte) begin
            pollClr = 1'b1;
            stNext  = ST_PREAD;
          end else begin
            stb.stepByte = 1'b1;
            stNext       = ST_NEXT;
          end
        end
      end
      ST_PREAD: begin
        if (tmr == ACC_END) begin
          tmrClr = 1'b1;
          if (pollMatch) begin
            doneNext = 1'b1;
            stNext   = ST_IDLE;
          end else if (pollCnt >= POLL_END) begin
            errNext  = 1'b1;
            codeNext = ERR_POLL;
            stNext   = ST_IDLE;
          end else begin
            pollInc = 1'b1;
            stNext  = ST_PGAP;
          end
        end
      end
      ST_PGAP: begin
        if (tmr == RCV_END) begin
          tmrClr = 1'b1;
          stNext = ST_PREAD;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      tmr     <= '0;
      gapCnt  <= '0;
      pollCnt <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      errCode <= '0;
    end else begin
      st      <= stNext;
      tmr     <= tmrClr ? '0 : tmr + TMR_W'(1);
      if (gapClr) gapCnt <= '0;
      else if (gapCnt < GAP_MAX) gapCnt <= gapCnt + GAP_W'(1);
      if (pollClr) pollCnt <= '0;
      else if (pollInc) pollCnt <= pollCnt + POLL_W'(1);
      done    <= doneNext;
      err     <= errNext;
      errCode <= codeNext;
    end
  end

  assign reqReady = (st == ST_IDLE);
  assign inReady  = (st == ST_NEXT) && !inPrefix;
  assign memCeN   = !((st == ST_WLOW) || (st == ST_PREAD));
  assign memWeN   = !(st == ST_WLOW);
  assign memOeN   = !(st == ST_PREAD);
  assign memDrive = (st == ST_NEXT) || (st == ST_WLOW) || (st == ST_WHIGH);

endmodule

// File: rtl/nvm_page_writer.sv
module nvm_page_writer
  import nvmw_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 6,
  parameter int T_WP       = 13,
  parameter int T_WPH      = 7,
  parameter int T_ACC      = 19,
  parameter int T_RCV      = 7,
  parameter int GAP_LIMIT  = 18000,
  parameter int POLL_LIMIT = 50000
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                reqValid,
  input  logic [ADDR_W-1:0]                   reqAddr,
  input  logic [$clog2((1<<PAGE_W)+1)-1:0]    reqCount,
  input  logic                                reqUnlock,
  output logic                                reqReady,
  input  logic                                inValid,
  input  logic [DATA_W-1:0]                   inData,
  output logic                                inReady,
  output logic                                memCeN,
  output logic                                memWeN,
  output logic                                memOeN,
  output logic [ADDR_W-1:0]                   memAddr,
  output logic [DATA_W-1:0]                   memDout,
  output logic                                memDrive,
  input  logic                                memPollBit,
  output logic                                done,
  output logic                                err,
  output logic [1:0]                          errCode
);

  localparam int CNT_W = $clog2((1 << PAGE_W) + 1);

  dpStrobe_t stb;
  logic inPrefix, lastByte, pollMatch;

  nvmw_ctrl #(
    .PAGE_W(PAGE_W), .CNT_W(CNT_W), .T_WP(T_WP), .T_WPH(T_WPH),
    .T_ACC(T_ACC), .T_RCV(T_RCV), .GAP_LIMIT(GAP_LIMIT), .POLL_LIMIT(POLL_LIMIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOffset(reqAddr[PAGE_W-1:0]), .reqCount(reqCount),
    .inValid(inValid), .inPrefix(inPrefix), .lastByte(lastByte), .pollMatch(pollMatch),
    .stb(stb), .reqReady(reqReady), .inReady(inReady),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memDrive(memDrive),
    .done(done), .err(err), .errCode(errCode)
  );

  nvmw_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqAddr(reqAddr), .reqCount(reqCount), .reqUnlock(reqUnlock),
    .inData(inData), .memPollBit(memPollBit),
    .memAddr(memAddr), .memDout(memDout),
    .inPrefix(inPrefix), .lastByte(lastByte), .pollMatch(pollMatch)
  );

endmodule

// File: rtl/nvmw_checker.sv
module nvmw_checker #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int T_WP   = 13,
  parameter int T_WPH  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              inReady,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDrive,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDout,
  input logic              done,
  input logic              err
);

  localparam int CW = $clog2(T_WP + T_WPH + 2) + 1;
  localparam logic [CW-1:0] CMAX  = '1;
  localparam logic [CW-1:0] LOMIN = CW'(T_WP);
  localparam logic [CW-1:0] HIMIN = CW'(T_WPH);

  logic [CW-1:0] loCnt, hiCnt;
  logic seenStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loCnt      <= '0;
      hiCnt      <= '0;
      seenStrobe <= 1'b0;
    end else begin
      if (!memWeN) begin
        loCnt <= (loCnt == CMAX) ? loCnt : loCnt + CW'(1);
        hiCnt <= '0;
      end else begin
        hiCnt <= (hiCnt == CMAX) ? hiCnt : hiCnt + CW'(1);
        loCnt <= '0;
      end
      if (!memWeN) seenStrobe <= 1'b1;
    end
  end

  a_r2_strobe_shape: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memOeN));

  a_r2_we_low_min: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (loCnt >= LOMIN));

  a_r3_we_high_min: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memWeN) && seenStrobe) |-> (hiCnt >= HIMIN));

  a_r4_bus_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memDout)));

  a_r8_read_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCeN && !memDrive));

  a_r10_handshake_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && inReady));

  a_r10_pulse_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memWeN && memOeN));

endmodule

bind nvm_page_writer nvmw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_WP(T_WP), .T_WPH(T_WPH)
) chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .inReady(inReady),
  .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memDrive(memDrive),
  .memAddr(memAddr), .memDout(memDout), .done(done), .err(err)
);

// File: tb/nvm_page_writer_tb_top.sv
`timescale 1ns/1ps
module nvm_page_writer_tb_top;

  localparam int T_WP = 13;
  localparam int T_WPH = 7;
  localparam int GAP_LIMIT = 500;
  localparam int POLL_LIMIT = 64;
  localparam int BUSY = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        reqValid = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [6:0]  reqCount = '0;
  logic        reqUnlock = 1'b0;
  logic        reqReady;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inReady;
  logic        memCeN, memWeN, memOeN, memDrive;
  logic [14:0] memAddr;
  logic [7:0]  memDout;
  logic [7:0]  memRd = 8'h00;
  logic        done, err;
  logic [1:0]  errCode;

  nvm_page_writer #(
    .T_WP(T_WP), .T_WPH(T_WPH), .GAP_LIMIT(GAP_LIMIT), .POLL_LIMIT(POLL_LIMIT)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqCount(reqCount),
    .reqUnlock(reqUnlock), .reqReady(reqReady), .inValid(inValid), .inData(inData),
    .inReady(inReady), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memAddr(memAddr), .memDout(memDout), .memDrive(memDrive), .memPollBit(memRd[7]),
    .done(done), .err(err), .errCode(errCode)
  );

  int nTests = 0;
  int nFail = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model and strobe monitor ----------------
  logic [7:0] mem [int];
  int logA [0:127];
  int logD [0:127];
  int logN = 0;
  int pendA [0:127];
  int pendD [0:127];
  int pendN = 0;
  int busyCnt = 0;
  bit stuck = 1'b0;
  logic [7:0] lastW = 8'h00;
  logic prevWe = 1'b1;
  int lowLen = 0;
  int hiLen = 0;
  bit seenW = 1'b0;
  logic [14:0] holdA;
  logic [7:0] holdD;
  bit stableOk;

  function automatic logic [7:0] memRead(input int a);
    if (mem.exists(a)) return mem[a];
    return 8'hFF;
  endfunction

  function automatic bit isPrefix();
    return pendN >= 3 && pendA[0] == 'h5555 && pendD[0] == 'hAA && pendA[1] == 'h2AAA
        && pendD[1] == 'h55 && pendA[2] == 'h5555 && pendD[2] == 'hA0;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (!memWeN && prevWe) begin
        if (seenW) check(hiLen >= T_WPH, "R3", "WE high gap", hiLen, T_WPH);
        lowLen = 1; holdA = memAddr; holdD = memDout; stableOk = 1'b1;
        if (memCeN || !memOeN) stableOk = 1'b0;
      end else if (!memWeN) begin
        lowLen++;
        if (memAddr != holdA || memDout != holdD) stableOk = 1'b0;
        if (memCeN || !memOeN) stableOk = 1'b0;
      end else if (memWeN && !prevWe) begin
        check(lowLen >= T_WP, "R2", "WE low width", lowLen, T_WP);
        check(stableOk, "R4", "bus or CE/OE moved during WE low", 0, 1);
        logA[logN] = holdA; logD[logN] = holdD; logN++;
        pendA[pendN] = holdA; pendD[pendN] = holdD; pendN++;
        lastW = holdD; busyCnt = BUSY; seenW = 1'b1; hiLen = 1;
      end else begin
        hiLen++;
        if (busyCnt > 0 && !stuck) begin
          busyCnt--;
          if (busyCnt == 0) begin
            for (int i = (isPrefix() ? 3 : 0); i < pendN; i++) mem[pendA[i]] = pendD[i][7:0];
            pendN = 0;
          end
        end
      end
      prevWe = memWeN;
      if (!memCeN && !memOeN)
        memRd = (busyCnt > 0) ? {~lastW[7], lastW[6:0]} : memRead(int'(memAddr));
      else
        memRd = 8'h00;
    end
  end

  // ---------------- transaction driver ----------------
  bit txnOver;
  bit gotDone, gotErr;
  int gotCode;

  task automatic sendByte(input logic [7:0] d, input int dly);
    for (int k = 0; k < dly && !txnOver; k++) @(negedge clk);
    if (txnOver) return;
    inValid = 1'b1; inData = d;
    while (!inReady && !txnOver) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitEnd();
    int c = 0;
    while (!(done || err) && c < 20000) begin @(negedge clk); c++; end
    gotDone = done; gotErr = err; gotCode = errCode;
    txnOver = 1'b1;
  endtask

  task automatic runTxn(input logic [14:0] a, input int cnt, input bit unl,
                        input int maxDly, input int sendN, input int expCode);
    logic [7:0] bq [64];
    int pre;
    for (int i = 0; i < 64; i++) bq[i] = 8'($urandom);
    pre = unl ? 3 : 0;
    logN = 0; txnOver = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqCount = 7'(cnt); reqUnlock = unl;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    fork
      begin
        for (int i = 0; i < sendN; i++) sendByte(bq[i], int'($urandom % (maxDly + 1)));
      end
      waitEnd();
    join
    if (expCode == 0) begin
      check(gotDone && !gotErr, "R8", "done pulse", int'(gotDone), 1);
      check(busyCnt == 0, "R8", "done while memory still busy", busyCnt, 0);
      check(logN == cnt + pre, "R5", "strobe count", logN, cnt + pre);
      if (unl) begin
        check(logA[0] == 'h5555 && logD[0] == 'hAA, "R6", "prefix step 0", logD[0], 'hAA);
        check(logA[1] == 'h2AAA && logD[1] == 'h55, "R6", "prefix step 1", logD[1], 'h55);
        check(logA[2] == 'h5555 && logD[2] == 'hA0, "R6", "prefix step 2", logD[2], 'hA0);
      end else if (logN > 0) begin
        check(logA[0] == int'(a), "R6", "no prefix when not asked", logA[0], int'(a));
      end
      for (int i = 0; i < cnt && i + pre < logN; i++) begin
        check(logA[i + pre] == int'(a) + i, "R5", "data address", logA[i + pre], int'(a) + i);
        check(logD[i + pre] == int'(bq[i]), "R5", "data byte", logD[i + pre], int'(bq[i]));
        check(memRead(int'(a) + i) == bq[i], "R5", "memory content", int'(memRead(int'(a) + i)), int'(bq[i]));
      end
    end else begin
      check(gotErr && !gotDone, "R10", "error pulse", int'(gotErr), 1);
      if (expCode == 1) begin
        check(gotCode == 1, "R1", "reject code", gotCode, 1);
        check(logN == 0, "R1", "no strobe on reject", logN, 0);
      end else if (expCode == 2) begin
        check(gotCode == 2, "R7", "gap code", gotCode, 2);
        check(logN == pre + sendN, "R7", "strobes before gap", logN, pre + sendN);
      end else begin
        check(gotCode == 3, "R9", "poll timeout code", gotCode, 3);
      end
    end
    @(negedge clk);
    check(reqReady && memCeN && memWeN && memOeN, "R10", "idle after request", int'(reqReady), 1);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(memCeN && memWeN && memOeN, "R10", "strobes after reset", {memCeN, memWeN, memOeN}, 7);
    check(reqReady && !inReady && !done && !err, "R10", "handshake after reset", int'(reqReady), 1);

    // R1 rejects
    runTxn(15'h0100, 0, 1'b0, 0, 0, 1);
    runTxn(15'h0100, 65, 1'b0, 0, 0, 1);
    runTxn(15'h103C, 5, 1'b1, 0, 0, 1);
    // boundary: exact page end, single byte, full page with prefix
    runTxn(15'h103C, 4, 1'b0, 3, 4, 0);
    runTxn(15'h0ABC, 1, 1'b0, 0, 1, 0);
    runTxn(15'h7FC0, 64, 1'b1, 2, 64, 0);
    // R7 payload gap
    runTxn(15'h2040, 4, 1'b0, 0, 1, 2);
    repeat (BUSY + 20) @(negedge clk);
    // R9 poll timeout with frozen memory
    stuck = 1'b1;
    runTxn(15'h3000, 2, 1'b1, 0, 2, 3);
    stuck = 1'b0;
    repeat (BUSY + 20) @(negedge clk);
    // random mix
    for (int t = 0; t < 25; t++) begin
      logic [14:0] a;
      int room;
      a = 15'($urandom);
      room = 64 - int'(a[5:0]);
      runTxn(a, 1 + int'($urandom % room), 1'($urandom), 12, 64, 0);
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule